// File: doc/BRIEF.md
# Four-Requester Fair Memory Arbiter

This block lets four caches share a single memory port: the data cache and the instruction cache of processor 0, and the same pair for processor 1. Each cache raises a request level with a 10-bit word address. Data caches also supply a write flag and 32-bit write data; instruction caches only read. The arbiter allows one memory transaction at a time. It copies the winner's address, flag and data into holding registers at the grant edge. It then drives these onto the memory port until the memory reports the transaction finished.

The winner is chosen by a fixed index order. One correction applies: a cache that received the previous grant cannot win again while any cache of the other processor is requesting. When a transfer finishes, the next pending request is granted on that same edge, so no idle cycle is inserted. Each cache has its own completion strobe. Each processor has a stall output that is high while one of its caches waits behind another cache's transfer.

The handshake on both sides is level-based. A requester keeps its request and its inputs steady until the grant edge. It may change its inputs freely after that edge, and it must clear its request on the clock edge that ends its strobe cycle. The memory applies back-pressure by holding wait high; for reads it also delays the data-valid pulse.

Top module: `mem_share_arb`

## Requirements
- R1: While reset (synchronous, active high) is applied, and in the cycle after it is released, the memory request, all four strobes and both stalls are low, and no previous grant is remembered.
- R2: Requester indices are 0 = processor 0 data, 1 = processor 0 instruction, 2 = processor 1 data, 3 = processor 1 instruction. With no previous grant, the lowest pending index wins. The grant is taken on the edge after the request is seen idle, and the memory request is high from the following cycle.
- R3: If the lowest pending index is the cache granted last, and a cache of the other processor is pending, the lowest pending cache of the other processor wins instead. A pending cache of the same processor does not trigger this rule.
- R4: At most one transaction is active. On the edge that completes a transfer, the next pending request, not counting the one just finished, is granted with no idle cycle. With nothing pending, the memory request drops.
- R5: A write completes in the first active cycle with memory wait low. A read completes only in an active cycle with wait low and memory data-valid high.
- R6: In the completion cycle, only the strobe bit of the granted requester is high, in that same cycle; it is low at all other times.
- R7: A processor's stall output is high in a cycle with an active transfer when one of that processor's caches, other than the granted one, is requesting. It is low otherwise.
- R8: The memory address equals the 10-bit word address the granted requester presented at its grant edge.
- R9: For a data cache, the memory write flag and write data are the values presented at the grant edge. For an instruction cache, the flag is 0 (read) and the data is zero.
- R10: Memory address, write flag and write data stay constant for the whole transfer, even if the requester changes its inputs after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 4 | Request level per requester (index per R2) |
| dc_we_i | input | 2 | Write flag of each processor's data cache (1 = write) |
| addr_i | input | 40 | Word address per requester, requester i at bits [10i+9:10i] |
| dc_wdata_i | input | 64 | Write data of each data cache, processor p at bits [32p+31:32p] |
| mem_wait_i | input | 1 | Memory still busy |
| mem_dvalid_i | input | 1 | Memory read data valid |
| mem_req_o | output | 1 | Memory transaction active |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| dvalid_o | output | 4 | Per-requester completion strobe |
| stall_o | output | 2 | Per-processor stall |

## Verification
Every result has a fixed due cycle, counted from the edge that samples a new request. The memory request and the stall outputs change in the first cycle after that edge. A strobe is due in the transfer's last cycle: memory latency plus one cycles after its grant for a write, plus the extra data-valid delay for a read. The following grant takes effect on that same edge. The bench keeps a running completion cycle for each granted transfer and compares strobes, stalls and memory-side fields at every falling edge against it. It scrambles the granted requester's inputs between grant and completion, and it clears a finished request one time unit after the completing edge.

// File: rtl/mem_share_arb_pkg.sv
package mem_share_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_PROC  = 2,
  parameter int N_CACHE = 2,
  localparam int N_REQ  = N_PROC * N_CACHE,
  localparam int IW     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] cand,
  input  logic             last_vld,
  input  logic [IW-1:0]    last_id,
  output logic             win_vld,
  output logic [IW-1:0]    win_id
);
  logic             first_vld;
  logic [IW-1:0]    first_id;
  logic [N_REQ-1:0] others;
  logic [N_REQ-1:0] eff;

  // lowest pending index under fixed order
  always_comb begin
    first_vld = 1'b0;
    first_id  = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        first_vld = 1'b1;
        first_id  = IW'(i);
      end
    end
  end

  // pending caches that belong to a processor other than the last winner's
  always_comb begin
    others = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if ((i / N_CACHE) != (int'(last_id) / N_CACHE)) others[i] = cand[i];
    end
  end

  assign eff = (last_vld && first_vld && (first_id == last_id) && (|others))
               ? others : cand;

  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (eff[i]) begin
        win_vld = 1'b1;
        win_id  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_capture.sv
module arb_capture #(
  parameter int N_PROC  = 2,
  parameter int N_CACHE = 2,
  parameter int MAW     = 10,
  parameter int DW      = 32,
  localparam int N_REQ  = N_PROC * N_CACHE,
  localparam int IW     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [IW-1:0]         sel,
  input  logic [N_REQ*MAW-1:0]  addr_flat,
  input  logic [N_PROC-1:0]     dc_we,
  input  logic [N_PROC*DW-1:0]  dc_wdata,
  output logic [MAW-1:0]        addr_q,
  output logic                  we_q,
  output logic [DW-1:0]         wdata_q
);
  int   sel_proc;
  logic sel_is_data;

  always_comb begin
    sel_proc    = int'(sel) / N_CACHE;
    sel_is_data = (int'(sel) % N_CACHE) == 0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q <= addr_flat[int'(sel)*MAW +: MAW];
      if (sel_is_data) begin
        we_q    <= dc_we[sel_proc];
        wdata_q <= dc_wdata[sel_proc*DW +: DW];
      end else begin
        we_q    <= 1'b0;
        wdata_q <= '0;
      end
    end
  end
endmodule

// File: rtl/arb_stall.sv
module arb_stall #(
  parameter int N_PROC  = 2,
  parameter int N_CACHE = 2,
  localparam int N_REQ  = N_PROC * N_CACHE
) (
  input  logic              busy,
  input  logic [N_REQ-1:0]  req,
  input  logic [N_REQ-1:0]  gnt_oh,
  output logic [N_PROC-1:0] stall
);
  for (genvar p = 0; p < N_PROC; p++) begin : g_proc
    localparam logic [N_REQ-1:0] PMASK = N_REQ'((2 ** N_CACHE) - 1) << (p * N_CACHE);
    assign stall[p] = busy && (|(req & ~gnt_oh & PMASK));
  end
endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb #(
  parameter int N_PROC  = 2,
  parameter int N_CACHE = 2,
  parameter int MAW     = 10,
  parameter int DW      = 32,
  localparam int N_REQ  = N_PROC * N_CACHE,
  localparam int IW     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_REQ-1:0]     req_i,
  input  logic [N_PROC-1:0]    dc_we_i,
  input  logic [N_REQ*MAW-1:0] addr_i,
  input  logic [N_PROC*DW-1:0] dc_wdata_i,
  input  logic                 mem_wait_i,
  input  logic                 mem_dvalid_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [MAW-1:0]       mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  output logic [N_REQ-1:0]     dvalid_o,
  output logic [N_PROC-1:0]    stall_o
);
  import mem_share_arb_pkg::*;

  arb_state_e       state_q;
  logic [IW-1:0]    gnt_q;
  logic [IW-1:0]    last_q;
  logic             last_vld_q;
  logic             busy;
  logic             done;
  logic             arb_en;
  logic [N_REQ-1:0] gnt_oh;
  logic [N_REQ-1:0] cand;
  logic             win_vld;
  logic [IW-1:0]    win_id;
  logic             cap_we;

  assign busy   = (state_q == ARB_BUSY);
  assign gnt_oh = busy ? (N_REQ'(1) << gnt_q) : '0;
  assign done   = busy && !mem_wait_i && (cap_we || mem_dvalid_i);
  assign arb_en = !busy || done;
  // the finishing requester still holds its request on the completing edge
  assign cand   = req_i & ~(done ? gnt_oh : '0);

  arb_pick #(.N_PROC(N_PROC), .N_CACHE(N_CACHE)) u_pick (
    .cand     (cand),
    .last_vld (last_vld_q),
    .last_id  (last_q),
    .win_vld  (win_vld),
    .win_id   (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ARB_IDLE;
      gnt_q      <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else if (arb_en) begin
      state_q <= win_vld ? ARB_BUSY : ARB_IDLE;
      if (win_vld) begin
        gnt_q      <= win_id;
        last_q     <= win_id;
        last_vld_q <= 1'b1;
      end
    end
  end

  arb_capture #(.N_PROC(N_PROC), .N_CACHE(N_CACHE), .MAW(MAW), .DW(DW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .load      (arb_en && win_vld),
    .sel       (win_id),
    .addr_flat (addr_i),
    .dc_we     (dc_we_i),
    .dc_wdata  (dc_wdata_i),
    .addr_q    (mem_addr_o),
    .we_q      (cap_we),
    .wdata_q   (mem_wdata_o)
  );

  arb_stall #(.N_PROC(N_PROC), .N_CACHE(N_CACHE)) u_stall (
    .busy   (busy),
    .req    (req_i),
    .gnt_oh (gnt_oh),
    .stall  (stall_o)
  );

  assign mem_req_o = busy;
  assign mem_we_o  = cap_we;
  assign dvalid_o  = done ? gnt_oh : '0;
endmodule

// File: rtl/mem_share_arb_chk.sv
module mem_share_arb_chk #(
  parameter int N_REQ  = 4,
  parameter int N_PROC = 2,
  parameter int MAW    = 10,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N_REQ-1:0]  req_i,
  input logic              mem_wait_i,
  input logic              mem_dvalid_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MAW-1:0]    mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic [N_REQ-1:0]  dvalid_o,
  input logic [N_PROC-1:0] stall_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_req_o && (stall_o == '0) && (dvalid_o == '0)));

  p_grant_from_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_o) |-> $past(|req_i));

  p_strobe_rule_r5: assert property (@(posedge clk) disable iff (rst)
    (|dvalid_o) |-> (mem_req_o && !mem_wait_i && (mem_we_o || mem_dvalid_i)));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dvalid_o));

  p_strobe_to_requester_r6: assert property (@(posedge clk) disable iff (rst)
    (|dvalid_o) |-> ((dvalid_o & req_i) == dvalid_o));

  p_stall_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (|stall_o) |-> mem_req_o);

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && (mem_wait_i || (!mem_we_o && !mem_dvalid_i)))
    |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

bind mem_share_arb mem_share_arb_chk #(
  .N_REQ(N_REQ), .N_PROC(N_PROC), .MAW(MAW), .DW(DW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_i        (req_i),
  .mem_wait_i   (mem_wait_i),
  .mem_dvalid_i (mem_dvalid_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .dvalid_o     (dvalid_o),
  .stall_o      (stall_o)
);

// File: tb/mem_share_arb_test.sv
`timescale 1ns/1ps
module mem_share_arb_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  req;
  logic [1:0]  dwe;
  logic [39:0] addr;
  logic [63:0] wdat;
  logic        mwait, mdv;
  logic        mreq, mwe;
  logic [9:0]  maddr;
  logic [31:0] mwd;
  logic [3:0]  dv;
  logic [1:0]  stall;

  always #4 clk = ~clk;

  mem_share_arb uut (
    .clk(clk), .rst(rst), .req_i(req), .dc_we_i(dwe), .addr_i(addr),
    .dc_wdata_i(wdat), .mem_wait_i(mwait), .mem_dvalid_i(mdv),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .dvalid_o(dv), .stall_o(stall)
  );

  // memory model: wait for lat cycles, reads add gap cycles before data-valid
  int lat = 1;
  int gap = 0;
  int cnt;
  logic mdone;
  assign mwait = mreq && (cnt < lat);
  assign mdv   = mreq && !mwe && (cnt == lat + gap);
  assign mdone = mreq && (cnt == (mwe ? lat : lat + gap));
  always_ff @(posedge clk) begin
    if (rst || !mreq || mdone) cnt <= 0;
    else cnt <= cnt + 1;
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [9:0]  oa [4];
  logic [31:0] ow [2];
  logic        owe[2];

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int low_bit(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  // expected service order, two bits per slot
  function automatic logic [7:0] exp_order(input logic [3:0] pat, input int last);
    logic [7:0] o = '0;
    logic [3:0] rem = pat;
    int prev = last;
    int k = 0;
    while (rem != 0) begin
      int f = low_bit(rem);
      if (prev >= 0 && f == prev) begin
        logic [3:0] oth = rem & ((prev < 2) ? 4'b1100 : 4'b0011);
        if (oth != 0) f = low_bit(oth);
      end
      o[k*2 +: 2] = 2'(f);
      rem[f] = 1'b0;
      prev = f;
      k++;
    end
    return o;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    req = '0;
    repeat (2) @(negedge clk);
    chk(!mreq && stall == 0 && dv == 0, "R1 reset outputs", {mreq, stall, dv}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mreq && stall == 0 && dv == 0, "R1 idle after reset", {mreq, stall, dv}, 0);
  endtask

  task automatic run_batch(input logic [3:0] pat, input int l, input int g_extra,
                           input int last, input int tag, output int newlast);
    logic [7:0] ord = exp_order(pat, last);
    int n = $countones(pat);
    int k = 0;
    int kstart = 0;
    logic [3:0] held;
    lat = l;
    gap = g_extra;
    for (int i = 0; i < 4; i++) begin
      oa[i] = 10'((tag * 97 + i * 211 + 5) & 1023);
      addr[i*10 +: 10] = oa[i];
    end
    for (int p = 0; p < 2; p++) begin
      owe[p] = 1'((tag >> p) & 1);
      ow[p]  = 32'hC0DE_0000 + 32'(tag * 16 + p);
      dwe[p] = owe[p];
      wdat[p*32 +: 32] = ow[p];
    end
    @(negedge clk);
    req  = pat;
    held = pat;
    for (int c = 1; c < 400; c++) begin
      int g;
      int dur;
      bit busy_e;
      bit comp;
      logic [3:0] exp_dv;
      logic [1:0] exp_st;
      @(negedge clk);
      busy_e = (k < n);
      g      = busy_e ? int'(ord[k*2 +: 2]) : 0;
      dur    = l + 1 + (((g % 2) == 0 && owe[g/2]) ? 0 : g_extra);
      comp   = busy_e && (c == kstart + dur);
      exp_dv = comp ? (4'b1 << g) : 4'b0;
      for (int p = 0; p < 2; p++)
        exp_st[p] = busy_e && (|(held & (4'b0011 << (2*p)) & ~(4'b1 << g)));
      chk(mreq == busy_e, "R4 one transfer, no idle gap", 64'(mreq), 64'(busy_e));
      chk(dv == exp_dv, "R6 strobe (R2 R3 order, R5 completion)", 64'(dv), 64'(exp_dv));
      chk(stall == exp_st, "R7 stall", 64'(stall), 64'(exp_st));
      if (!busy_e) break;
      if (comp) begin
        logic        ewe = ((g % 2) == 0) ? owe[g/2] : 1'b0;
        logic [31:0] ewd = ((g % 2) == 0) ? ow[g/2] : 32'h0;
        chk(maddr == oa[g], "R8 address (R10 held)", 64'(maddr), 64'(oa[g]));
        chk(mwe == ewe, "R9 write flag", 64'(mwe), 64'(ewe));
        chk(mwd == ewd, "R9 write data", 64'(mwd), 64'(ewd));
        k++;
        kstart = c;
        @(posedge clk);
        #1;
        req[g]  = 1'b0;
        held[g] = 1'b0;
      end else begin
        // requester disturbs its inputs after the grant
        addr[g*10 +: 10] = ~oa[g];
        if ((g % 2) == 0) begin
          dwe[g/2] = ~owe[g/2];
          wdat[(g/2)*32 +: 32] = ~ow[g/2];
        end
      end
    end
    newlast = int'(ord[(n-1)*2 +: 2]);
  endtask

  initial begin
    int tag = 0;
    int last;
    int nl;
    rst = 1'b1; req = '0; dwe = '0; addr = '0; wdat = '0;
    // R2 R4 R5: every pattern from a fresh reset, two latencies
    for (int l = 0; l < 3; l += 2) begin
      for (int pat = 1; pat < 16; pat++) begin
        do_reset();
        run_batch(4'(pat), l, pat % 2, -1, tag, nl);
        tag++;
      end
    end
    // R3 directed: repeat winner loses to the other processor, not to its own
    do_reset();
    run_batch(4'b0001, 1, 0, -1, tag++, last);
    run_batch(4'b1001, 1, 1, last, tag++, last);
    run_batch(4'b0110, 1, 0, last, tag++, last);
    run_batch(4'b1100, 1, 2, last, tag++, last);
    run_batch(4'b0100, 0, 0, last, tag++, last);
    run_batch(4'b0101, 0, 0, last, tag++, last);
    // R3 sweep carrying the previous winner between batches
    for (int pat = 1; pat < 16; pat++) begin
      run_batch(4'(pat), 1, (pat >> 1) % 2, last, tag, last);
      tag++;
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule